// File: doc/BRIEF.md
# Elliptic Curve Scalar Multiply Controller

This block sequences a left-to-right double-and-add multiplication of a fixed base point G by a multi-word scalar. It keeps a running point R in Jacobian coordinates (X, Y, Z) and a scratch point T. The arithmetic lives in four external units: point doubling, point addition with G, a combined inverse-square/inverse-cube unit and a modular multiplier. The controller drives each unit with a one-cycle go pulse, presents the operands on a shared operand bus and takes the answer from a shared result bus when that unit signals completion.

Every scalar bit costs exactly one doubling and one addition. The addition result is kept only when the bit is set; otherwise R takes the doubled value. As a result, the command stream is identical for every scalar. After bit 0, Z is inverted once to give Z^-2 and Z^-3. Two multiplies then give the affine coordinates. A final Z of zero means the result is the point at infinity: it is reported with both coordinates forced to zero and a flag set.

The scalar is latched when a run starts. Results stay on the outputs until the next run completes.

Top module: `ecsm_ctrl`

## Requirements
- R1: After reset, busy, done and all four go outputs are 0, and res_x, res_y and res_inf are 0.
- R2: A run starts with R = (X=1, Y=1, Z=0). The first doubling command therefore sees op_a=1, op_b=1, op_c=0.
- R3: Scalar bits are consumed from bit NB-1 (the top bit of the top word) down to bit 0, where NB = WORDS*WORD_W. Word w occupies bits w*WORD_W+WORD_W-1 down to w*WORD_W.
- R4: For each bit a doubling of R is issued (op_a/op_b/op_c = X/Y/Z of R), then an addition whose operands are the doubling result (rs_a/rs_b/rs_c = X/Y/Z). Each go is a one-cycle pulse, and no command is issued while the previous one awaits its done.
- R5: After the addition, R becomes the addition result when the current bit is 1, and the doubling result when it is 0.
- R6: Every run issues exactly 2*NB+3 commands, whatever the scalar. At most one go output is high in any cycle.
- R7: After the last bit, one inverse command is issued with op_a = Z. Its answer gives Z^-2 on rs_a and Z^-3 on rs_b. Then a multiply with op_a=X, op_b=Z^-2 is issued, followed by a multiply with op_a=Y, op_b=Z^-3. Multiply results are read from rs_a.
- R8: If the final Z is zero, res_x=0, res_y=0 and res_inf=1. Otherwise res_inf=0, and res_x and res_y are the two products.
- R9: busy is high from the cycle after an accepted start until the cycle of the one-cycle done pulse, and low afterwards. The results are valid at done and held until the next done.
- R10: A start pulse while busy is ignored, and so are scalar input changes during a run. The result is that of the scalar latched at the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| scalar | input | NB | Multiplier value, latched at an accepted start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |
| res_x | output | CW | Affine x of the result |
| res_y | output | CW | Affine y of the result |
| res_inf | output | 1 | Result is the point at infinity |
| dbl_go | output | 1 | Start point doubling |
| add_go | output | 1 | Start addition of G |
| inv_go | output | 1 | Start inverse-square/cube |
| mul_go | output | 1 | Start modular multiply |
| op_a | output | CW | Operand A (X, or Z for inverse) |
| op_b | output | CW | Operand B (Y, or inverse power) |
| op_c | output | CW | Operand C (Z) |
| dbl_done | input | 1 | Doubling finished, result on rs bus |
| add_done | input | 1 | Addition finished, result on rs bus |
| inv_done | input | 1 | Inverse finished, Z^-2 on rs_a, Z^-3 on rs_b |
| mul_done | input | 1 | Multiply finished, product on rs_a |
| rs_a | input | CW | Result A |
| rs_b | input | CW | Result B |
| rs_c | input | CW | Result C |

## Verification
The scalar patterns are chosen so that each one separates a different fault.

- A zero scalar discards every sum and must end at infinity with zeroed coordinates.
- A single set bit at the top, at the bottom, or just above a word boundary exposes a reversed or skewed bit order, because the intermediate points differ from the first command on.
- All ones keeps every sum.
- Alternating and random scalars mix keeping and discarding.

The unit models check every operand against a running model of R. They also vary their latency, which exposes any command issued early or any result captured from the wrong unit. A stray start with a changed scalar in mid-run must leave both the trace and the result untouched.

// File: rtl/ecsm_pkg.sv
package ecsm_pkg;
   typedef enum logic [3:0] {
      PH_IDLE, PH_DBL_GO, PH_DBL_W, PH_ADD_GO, PH_ADD_W,
      PH_INV_GO, PH_INV_W, PH_MX_GO, PH_MX_W, PH_MY_GO, PH_MY_W, PH_FIN
   } phase_t;

   localparam int unsigned COORDS = 3;
endpackage

// File: rtl/ecsm_scalar_walk.sv
module ecsm_scalar_walk #(
   parameter int unsigned NB         = 256,
   parameter bit          SHIFT_MODE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [NB-1:0] scalar,
   output logic          cur_bit,
   output logic          last
);
   localparam int unsigned  IW  = (NB > 1) ? $clog2(NB) : 1;
   localparam logic [IW-1:0] TOP = IW'(NB - 1);

   logic [IW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     idx_q <= '0;
      else if (load)                  idx_q <= TOP;
      else if (step && idx_q != '0)   idx_q <= idx_q - 1'b1;
   end

   assign last = (idx_q == '0);

   generate
      if (SHIFT_MODE) begin : g_shift
         logic [NB-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sh_q <= '0;
            else if (load)  sh_q <= scalar;
            else if (step)  sh_q <= {sh_q[NB-2:0], 1'b0};
         end
         assign cur_bit = sh_q[NB-1];
      end else begin : g_index
         logic [NB-1:0] k_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     k_q <= '0;
            else if (load)  k_q <= scalar;
         end
         assign cur_bit = k_q[idx_q];
      end
   endgenerate

   // R3: walk starts at the top bit and moves down by one per step
   assert_start_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (idx_q == TOP));
   assert_walk_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !last && !load) |=> (idx_q == $past(idx_q) - 1'b1));
endmodule

// File: rtl/ecsm_seq.sv
module ecsm_seq
   import ecsm_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  logic   last,
   input  logic   dbl_done,
   input  logic   add_done,
   input  logic   inv_done,
   input  logic   mul_done,
   output phase_t ph,
   output logic   busy,
   output logic   done,
   output logic   load,
   output logic   cap_dbl,
   output logic   cap_add,
   output logic   cap_inv,
   output logic   cap_mx,
   output logic   cap_my,
   output logic   dbl_go,
   output logic   add_go,
   output logic   inv_go,
   output logic   mul_go
);
   phase_t ph_q, ph_d;

   always_comb begin
      ph_d = ph_q;
      case (ph_q)
         PH_IDLE:   if (start)    ph_d = PH_DBL_GO;
         PH_DBL_GO:               ph_d = PH_DBL_W;
         PH_DBL_W:  if (dbl_done) ph_d = PH_ADD_GO;
         PH_ADD_GO:               ph_d = PH_ADD_W;
         PH_ADD_W:  if (add_done) ph_d = last ? PH_INV_GO : PH_DBL_GO;
         PH_INV_GO:               ph_d = PH_INV_W;
         PH_INV_W:  if (inv_done) ph_d = PH_MX_GO;
         PH_MX_GO:                ph_d = PH_MX_W;
         PH_MX_W:   if (mul_done) ph_d = PH_MY_GO;
         PH_MY_GO:                ph_d = PH_MY_W;
         PH_MY_W:   if (mul_done) ph_d = PH_FIN;
         PH_FIN:                  ph_d = PH_IDLE;
         default:                 ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign ph      = ph_q;
   assign busy    = (ph_q != PH_IDLE);
   assign done    = (ph_q == PH_FIN);
   assign load    = (ph_q == PH_IDLE) && start;
   assign cap_dbl = (ph_q == PH_DBL_W) && dbl_done;
   assign cap_add = (ph_q == PH_ADD_W) && add_done;
   assign cap_inv = (ph_q == PH_INV_W) && inv_done;
   assign cap_mx  = (ph_q == PH_MX_W)  && mul_done;
   assign cap_my  = (ph_q == PH_MY_W)  && mul_done;
   assign dbl_go  = (ph_q == PH_DBL_GO);
   assign add_go  = (ph_q == PH_ADD_GO);
   assign inv_go  = (ph_q == PH_INV_GO);
   assign mul_go  = (ph_q == PH_MX_GO) || (ph_q == PH_MY_GO);

   // R6: never two commands in one cycle
   assert_one_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dbl_go, add_go, inv_go, mul_go}));
   // R4: every go is a single-cycle pulse
   assert_go_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dbl_go || add_go || inv_go || mul_go) |=> !(dbl_go || add_go || inv_go || mul_go));
   // R7: the last addition leads straight to the inverse
   assert_inv_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_add && last) |=> inv_go);
   // R9: busy holds until done, and drops right after it
   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done));
endmodule

// File: rtl/ecsm_point_store.sv
module ecsm_point_store
   import ecsm_pkg::*;
#(
   parameter int unsigned CW = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  phase_t        ph,
   input  logic          load,
   input  logic          cap_dbl,
   input  logic          cap_add,
   input  logic          sum_keep,
   input  logic          cap_inv,
   input  logic          cap_mx,
   input  logic          cap_my,
   input  logic [CW-1:0] rs_a,
   input  logic [CW-1:0] rs_b,
   input  logic [CW-1:0] rs_c,
   output logic [CW-1:0] op_a,
   output logic [CW-1:0] op_b,
   output logic [CW-1:0] op_c,
   output logic [CW-1:0] res_x,
   output logic [CW-1:0] res_y,
   output logic          res_inf
);
   localparam logic [CW-1:0] ONE = CW'(1);

   // coordinate 0 = X, 1 = Y, 2 = Z
   logic [COORDS-1:0][CW-1:0] r_q, t_q, rs_v;
   logic [CW-1:0]             ia2_q, ia3_q, px_q;
   logic                      z_zero;

   function automatic logic [CW-1:0] inf_coord(input int unsigned c);
      return (c == 2) ? '0 : ONE;
   endfunction

   assign rs_v   = {rs_c, rs_b, rs_a};
   assign z_zero = (r_q[2] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int unsigned c = 0; c < COORDS; c++) begin
            r_q[c] <= inf_coord(c);
            t_q[c] <= '0;
         end
      end else begin
         for (int unsigned c = 0; c < COORDS; c++) begin
            if (load)         r_q[c] <= inf_coord(c);
            else if (cap_add) r_q[c] <= sum_keep ? rs_v[c] : t_q[c];
            if (cap_dbl)      t_q[c] <= rs_v[c];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ia2_q   <= '0;
         ia3_q   <= '0;
         px_q    <= '0;
         res_x   <= '0;
         res_y   <= '0;
         res_inf <= 1'b0;
      end else begin
         if (cap_inv) begin
            ia2_q <= rs_a;
            ia3_q <= rs_b;
         end
         if (cap_mx) px_q <= rs_a;
         if (cap_my) begin
            res_x   <= z_zero ? '0 : px_q;
            res_y   <= z_zero ? '0 : rs_a;
            res_inf <= z_zero;
         end
      end
   end

   always_comb begin
      op_a = '0;
      op_b = '0;
      op_c = '0;
      case (ph)
         PH_DBL_GO, PH_DBL_W: begin op_a = r_q[0]; op_b = r_q[1]; op_c = r_q[2]; end
         PH_ADD_GO, PH_ADD_W: begin op_a = t_q[0]; op_b = t_q[1]; op_c = t_q[2]; end
         PH_INV_GO, PH_INV_W: op_a = r_q[2];
         PH_MX_GO,  PH_MX_W:  begin op_a = r_q[0]; op_b = ia2_q; end
         PH_MY_GO,  PH_MY_W:  begin op_a = r_q[1]; op_b = ia3_q; end
         default: ;
      endcase
   end

   // R2: a run begins from the point at infinity (1, 1, 0)
   assert_inf_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (r_q[0] == ONE && r_q[1] == ONE && r_q[2] == '0));
   // R5: a clear bit restores the doubled point, a set bit keeps the sum
   assert_keep_double_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_add && !sum_keep) |=> (r_q == $past(t_q)));
   assert_take_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_add && sum_keep) |=> (r_q == $past(rs_v)));
   // R8: infinity flag implies zeroed coordinates
   assert_inf_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_inf |-> (res_x == '0 && res_y == '0));
endmodule

// File: rtl/ecsm_ctrl.sv
module ecsm_ctrl
   import ecsm_pkg::*;
#(
   parameter int unsigned WORDS        = 8,
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned CW           = 256,
   parameter bit          SCALAR_SHIFT = 1'b0,
   localparam int unsigned NB          = WORDS * WORD_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NB-1:0] scalar,
   output logic          busy,
   output logic          done,
   output logic [CW-1:0] res_x,
   output logic [CW-1:0] res_y,
   output logic          res_inf,
   output logic          dbl_go,
   output logic          add_go,
   output logic          inv_go,
   output logic          mul_go,
   output logic [CW-1:0] op_a,
   output logic [CW-1:0] op_b,
   output logic [CW-1:0] op_c,
   input  logic          dbl_done,
   input  logic          add_done,
   input  logic          inv_done,
   input  logic          mul_done,
   input  logic [CW-1:0] rs_a,
   input  logic [CW-1:0] rs_b,
   input  logic [CW-1:0] rs_c
);
   generate
      if (WORDS < 1 || WORD_W < 1 || NB < 2) begin : g_bad_scalar
         $error("ecsm_ctrl: scalar must be at least two bits wide");
      end
      if (CW < 2) begin : g_bad_coord
         $error("ecsm_ctrl: coordinate width must be at least two bits");
      end
   endgenerate

   phase_t ph;
   logic   load, cap_dbl, cap_add, cap_inv, cap_mx, cap_my;
   logic   cur_bit, last;

   ecsm_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .last     (last),
      .dbl_done (dbl_done),
      .add_done (add_done),
      .inv_done (inv_done),
      .mul_done (mul_done),
      .ph       (ph),
      .busy     (busy),
      .done     (done),
      .load     (load),
      .cap_dbl  (cap_dbl),
      .cap_add  (cap_add),
      .cap_inv  (cap_inv),
      .cap_mx   (cap_mx),
      .cap_my   (cap_my),
      .dbl_go   (dbl_go),
      .add_go   (add_go),
      .inv_go   (inv_go),
      .mul_go   (mul_go)
   );

   ecsm_scalar_walk #(.NB(NB), .SHIFT_MODE(SCALAR_SHIFT)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (cap_add),
      .scalar  (scalar),
      .cur_bit (cur_bit),
      .last    (last)
   );

   ecsm_point_store #(.CW(CW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .ph       (ph),
      .load     (load),
      .cap_dbl  (cap_dbl),
      .cap_add  (cap_add),
      .sum_keep (cur_bit),
      .cap_inv  (cap_inv),
      .cap_mx   (cap_mx),
      .cap_my   (cap_my),
      .rs_a     (rs_a),
      .rs_b     (rs_b),
      .rs_c     (rs_c),
      .op_a     (op_a),
      .op_b     (op_b),
      .op_c     (op_c),
      .res_x    (res_x),
      .res_y    (res_y),
      .res_inf  (res_inf)
   );
endmodule

// File: tb/test_ecsm_ctrl.sv
module test_ecsm_ctrl;
   localparam int unsigned WORDS = 2;
   localparam int unsigned WW    = 8;
   localparam int unsigned NB    = WORDS * WW;
   localparam int unsigned CW    = 32;
   localparam int          NCMD  = 2 * NB + 3;
   localparam logic [CW-1:0] GX = 32'h1234_5678;
   localparam logic [CW-1:0] GY = 32'h9ABC_DEF0;
   localparam int NVEC = 7;
   localparam logic [NB-1:0] VEC [NVEC] = '{
      16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'hA5C3, 16'h0100, 16'h00FF };

   logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [NB-1:0] scalar = '0;
   logic          busy, done, res_inf, dbl_go, add_go, inv_go, mul_go;
   logic [CW-1:0] res_x, res_y, op_a, op_b, op_c;
   logic          dbl_done = 1'b0, add_done = 1'b0, inv_done = 1'b0, mul_done = 1'b0;
   logic [CW-1:0] rs_a = '0, rs_b = '0, rs_c = '0;

   int errors = 0, checks = 0;

   always #2ns clk = ~clk;

   ecsm_ctrl #(.WORDS(WORDS), .WORD_W(WW), .CW(CW)) i_ecsm_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar),
      .busy(busy), .done(done), .res_x(res_x), .res_y(res_y), .res_inf(res_inf),
      .dbl_go(dbl_go), .add_go(add_go), .inv_go(inv_go), .mul_go(mul_go),
      .op_a(op_a), .op_b(op_b), .op_c(op_c),
      .dbl_done(dbl_done), .add_done(add_done), .inv_done(inv_done), .mul_done(mul_done),
      .rs_a(rs_a), .rs_b(rs_b), .rs_c(rs_c));

   // stand-in arithmetic: only the sequencing matters here
   function automatic void m_dbl(input logic [CW-1:0] x, y, z, output logic [CW-1:0] ox, oy, oz);
      if (z == '0) begin ox = 1; oy = 1; oz = 0; end
      else begin ox = x * 3 + y; oy = y * 5 + 1; oz = (z * 2 + x) | 1; end
   endfunction
   function automatic void m_add(input logic [CW-1:0] x, y, z, output logic [CW-1:0] ox, oy, oz);
      if (z == '0) begin ox = GX; oy = GY; oz = 1; end
      else begin ox = x + GX * z; oy = y ^ GY; oz = (z * 3) | 1; end
   endfunction
   function automatic void m_inv(input logic [CW-1:0] z, output logic [CW-1:0] a2, a3);
      a2 = ~z; a3 = z * 7 + 5;
   endfunction

   function automatic void ref_run(input logic [NB-1:0] k, output logic [CW-1:0] ex, ey, output logic ei);
      logic [CW-1:0] x, y, z, tx, ty, tz, ax, ay, az, a2, a3;
      x = 1; y = 1; z = 0;
      for (int i = NB - 1; i >= 0; i--) begin
         m_dbl(x, y, z, tx, ty, tz);
         m_add(tx, ty, tz, ax, ay, az);
         if (k[i]) begin x = ax; y = ay; z = az; end
         else      begin x = tx; y = ty; z = tz; end
      end
      m_inv(z, a2, a3);
      ei = (z == '0);
      ex = ei ? '0 : x * a2;
      ey = ei ? '0 : y * a3;
   endfunction

   // unit models: check each command against a running copy of R
   logic [NB-1:0] cur_k = '0;
   logic [CW-1:0] mx, my, mz, mtx, mty, mtz, ma2, ma3;
   int  mstep = 0, tr_err = 0, first_err = 0, wcnt = 0, pk = 0, ngo, bi;
   bit  pend = 0;

   always @(negedge clk) begin
      dbl_done = 0; add_done = 0; inv_done = 0; mul_done = 0;
      if (pend) begin
         if (wcnt == 0) begin
            case (pk)
               0: dbl_done = 1;
               1: add_done = 1;
               2: inv_done = 1;
               default: mul_done = 1;
            endcase
            pend = 0;
         end else wcnt--;
      end
      ngo = int'(dbl_go) + int'(add_go) + int'(inv_go) + int'(mul_go);
      if (ngo > 1 || (ngo == 1 && pend)) tr_err++;
      if (ngo == 1) begin
         if (mstep < 2 * NB && mstep % 2 == 0) begin
            if (!dbl_go || op_a != mx || op_b != my || op_c != mz) tr_err++;
            if (mstep == 0 && !(op_a == 1 && op_b == 1 && op_c == 0)) first_err++;
            m_dbl(mx, my, mz, mtx, mty, mtz);
            rs_a = mtx; rs_b = mty; rs_c = mtz; pk = 0;
         end else if (mstep < 2 * NB) begin
            if (!add_go || op_a != mtx || op_b != mty || op_c != mtz) tr_err++;
            m_add(mtx, mty, mtz, rs_a, rs_b, rs_c);
            bi = NB - 1 - mstep / 2;
            if (cur_k[bi]) begin mx = rs_a; my = rs_b; mz = rs_c; end
            else           begin mx = mtx;  my = mty;  mz = mtz;  end
            pk = 1;
         end else if (mstep == 2 * NB) begin
            if (!inv_go || op_a != mz) tr_err++;
            m_inv(mz, ma2, ma3);
            rs_a = ma2; rs_b = ma3; rs_c = '0; pk = 2;
         end else if (mstep == 2 * NB + 1) begin
            if (!mul_go || op_a != mx || op_b != ma2) tr_err++;
            rs_a = op_a * op_b; pk = 3;
         end else if (mstep == 2 * NB + 2) begin
            if (!mul_go || op_a != my || op_b != ma3) tr_err++;
            rs_a = op_a * op_b; pk = 3;
         end else tr_err++;
         pend = 1;
         wcnt = mstep % 3;
         mstep++;
      end
   end

   task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_k(input logic [NB-1:0] k, input bit poke);
      logic [CW-1:0] ex, ey;
      logic ei, held_x;
      bit seen = 0, busy_ok = 1;
      ref_run(k, ex, ey, ei);
      tr_err = 0; first_err = 0; mstep = 0;
      mx = 1; my = 1; mz = 0;
      cur_k = k; scalar = k; start = 1;
      @(negedge clk);
      start = 0; scalar = ~k;
      for (int cyc = 0; cyc < 5000 && !seen; cyc++) begin
         if (!busy) busy_ok = 0;
         if (done) seen = 1;
         else begin
            start = poke && (cyc == 20);
            @(negedge clk);
         end
      end
      start = 0;
      chk("watchdog run ended", CW'(seen), 1);
      chk("R9 busy through run", CW'(busy_ok), 1);
      chk("R2 first doubling from infinity", CW'(first_err), 0);
      chk("R3 R4 R5 R10 command trace", CW'(tr_err), 0);
      chk("R6 command count", CW'(mstep), CW'(NCMD));
      chk("R7 R8 res_x", res_x, ex);
      chk("R7 R8 res_y", res_y, ey);
      chk("R8 res_inf", CW'(res_inf), CW'(ei));
      @(negedge clk);
      chk("R9 done single pulse", CW'(done), 0);
      chk("R9 idle after done", CW'(busy), 0);
      repeat (3) @(negedge clk);
      held_x = (res_x == ex) && (res_y == ey);
      chk("R9 results held", CW'(held_x), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", CW'(busy), 0);
      chk("R1 done", CW'(done), 0);
      chk("R1 go outputs", CW'({dbl_go, add_go, inv_go, mul_go}), 0);
      chk("R1 result", res_x | res_y | CW'(res_inf), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk("R1 no command without start", CW'({dbl_go, add_go, inv_go, mul_go, busy}), 0);
      for (int v = 0; v < NVEC; v++) run_k(VEC[v], 1'b0);
      for (int r = 0; r < 3; r++) run_k(NB'($urandom), 1'b0);
      // R10: stray start with a changed scalar in mid-run
      run_k(16'h5A3C, 1'b1);
      // R8: zero scalar again after a nonzero one must reach infinity
      run_k(16'h0000, 1'b1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #600us;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule